// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is a bank of general-purpose I/O pins with a small register interface. Each pin has three registers. The direction register decides whether the pin drives or listens. The output latch holds the value that is driven when the pin is an output. The port register reads back the live pin level through a two-flop synchroniser. A write to the port register does not create a fourth register: it goes into the output latch. Software therefore has two views of each pin. Reading the port register gives the level actually present on the pad. Reading the latch register gives the stored drive value, which read-modify-write sequences need.

Toward the pads the block produces a drive value and an output enable for every pin. A per-pin peripheral-enable input hands the pad to an on-chip peripheral. For such a pin, the peripheral's own drive value and output enable replace the general-purpose ones. The register bus has a write strobe, a two-bit address and a write data word. Read data is returned combinationally for the address currently presented.

Top module: `gpio_bank`

## Requirements
- R1: While reset is asserted (`rst_n` low), the direction register is all ones (every pin an input) and the latch is all zeros. As a result `pad_oe` is all zeros and `pad_out` is all zeros for every pin whose peripheral enable is low.
- R2: When `bus_wr` is high with address 0, the direction register takes `bus_wdata` at the next rising clock edge. Reading address 0 returns the direction register. A direction bit of 1 makes the pin an input and 0 makes it an output.
- R3: When `bus_wr` is high with address 1 (the port register), `bus_wdata` is stored into the output latch at the next rising edge, and the direction register is left unchanged.
- R4: When `bus_wr` is high with address 2, the output latch takes `bus_wdata` at the next rising edge.
- R5: Reading address 1 returns `pad_in` as it was sampled two rising edges earlier, through a two-stage synchroniser that is cleared by reset.
- R6: Reading address 2 returns the latch contents, whatever levels `pad_in` shows.
- R7: For a pin whose `periph_en` bit is 0, `pad_out` equals that pin's latch bit. `pad_oe` equals the inverse of its direction bit, so the pin drives only when it is set as an output.
- R8: For a pin whose `periph_en` bit is 1, `pad_out` equals `periph_out` and `pad_oe` equals `periph_oe` for that pin, whatever its direction and latch bits hold.
- R9: Address 3 reads as all zeros, and a write to address 3 changes neither the direction register nor the latch.
- R10: While `bus_wr` is low, neither the direction register nor the latch changes, whatever `bus_addr` and `bus_wdata` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register select: 0 direction, 1 port, 2 latch, 3 unused |
| bus_wdata | input | NPINS | Write data, one bit per pin |
| bus_rdata | output | NPINS | Read data for the address presented (combinational) |
| pad_in | input | NPINS | Raw level seen at each pad |
| pad_out | output | NPINS | Value driven toward each pad |
| pad_oe | output | NPINS | Output enable toward each pad, 1 means drive |
| periph_en | input | NPINS | Per-pin peripheral takeover |
| periph_out | input | NPINS | Peripheral drive value per pin |
| periph_oe | input | NPINS | Peripheral output enable per pin |

## Verification
A register write becomes visible one rising edge after the strobe is sampled. From then on it appears both in read data and at the pad outputs. A change on `pad_in` reaches a port-register read only after the second rising edge. The pad mux and read mux react within the same cycle to `periph_en`, `periph_out`, `periph_oe` and `bus_addr`. The bench keeps a behavioural model that it advances at each rising edge. The model holds the register values and a two-entry history queue of pad samples. The bench changes inputs shortly after the falling edge and compares every output at the next falling edge. Each result is therefore checked in exactly the cycle in which it falls due.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register select codes on the two-bit bus address
    typedef enum logic [1:0] {
        SEL_DIR  = 2'd0,
        SEL_PORT = 2'd1,
        SEL_LAT  = 2'd2,
        SEL_VOID = 2'd3
    } reg_sel_e;

    localparam int unsigned ADDR_W = 2;

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] first;
        logic [WIDTH-1:0] second;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d        = sync_q;
        sync_d.first  = raw_i;
        sync_d.second = sync_q.first;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign sync_o = sync_q.second;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  reg_sel_e         sel_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] lat_o
);

    typedef struct packed {
        logic [WIDTH-1:0] dir;
        logic [WIDTH-1:0] lat;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            unique case (sel_i)
                SEL_DIR:  regs_d.dir = wdata_i;
                SEL_PORT: regs_d.lat = wdata_i;   // port writes land in the latch
                SEL_LAT:  regs_d.lat = wdata_i;
                default:  ;                       // unused slot, no effect
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.dir <= '1;
            regs_q.lat <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign dir_o = regs_q.dir;
    assign lat_o = regs_q.lat;

    // R2
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_DIR) |=> (dir_o == $past(wdata_i)));

    // R3
    port_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_PORT) |=> (lat_o == $past(wdata_i) && $stable(dir_o)));

    // R4
    lat_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_LAT) |=> (lat_o == $past(wdata_i)));

    // R9
    void_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && sel_i == SEL_VOID) |=> ($stable(dir_o) && $stable(lat_o)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> ($stable(dir_o) && $stable(lat_o)));

endmodule

// File: rtl/gpio_bank_padmux.sv
module gpio_bank_padmux #(
    parameter int unsigned WIDTH = 16
) (
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] lat_i,
    input  logic [WIDTH-1:0] periph_en_i,
    input  logic [WIDTH-1:0] periph_out_i,
    input  logic [WIDTH-1:0] periph_oe_i,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_oe_o
);

    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        always_comb begin
            if (periph_en_i[p]) begin
                pad_out_o[p] = periph_out_i[p];
                pad_oe_o[p]  = periph_oe_i[p];
            end else begin
                pad_out_o[p] = lat_i[p];
                pad_oe_o[p]  = ~dir_i[p];
            end
        end
    end

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned NPINS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    input  logic [NPINS-1:0]  periph_en,
    input  logic [NPINS-1:0]  periph_out,
    input  logic [NPINS-1:0]  periph_oe
);

    reg_sel_e         sel;
    logic [NPINS-1:0] dir_w, lat_w, port_w;

    assign sel = reg_sel_e'(bus_addr);

    gpio_bank_sync #(.WIDTH(NPINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pad_in),
        .sync_o (port_w)
    );

    gpio_bank_regs #(.WIDTH(NPINS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (bus_wr),
        .sel_i   (sel),
        .wdata_i (bus_wdata),
        .dir_o   (dir_w),
        .lat_o   (lat_w)
    );

    gpio_bank_padmux #(.WIDTH(NPINS)) u_mux (
        .dir_i        (dir_w),
        .lat_i        (lat_w),
        .periph_en_i  (periph_en),
        .periph_out_i (periph_out),
        .periph_oe_i  (periph_oe),
        .pad_out_o    (pad_out),
        .pad_oe_o     (pad_oe)
    );

    always_comb begin
        unique case (sel)
            SEL_DIR:  bus_rdata = dir_w;
            SEL_PORT: bus_rdata = port_w;   // live pin view
            SEL_LAT:  bus_rdata = lat_w;    // stored drive value
            default:  bus_rdata = '0;
        endcase
    end

    // R7
    gp_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~periph_en) & dir_w) == '0);

endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;

    localparam int N = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [1:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out, pad_oe;
    logic [N-1:0] periph_en = '0, periph_out = '0, periph_oe = '0;

    gpio_bank #(.NPINS(N)) u0 (
        .clk, .rst_n, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
        .pad_in, .pad_out, .pad_oe, .periph_en, .periph_out, .periph_oe
    );

    always #5 clk = ~clk;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference state
    logic [N-1:0] m_dir = '1;
    logic [N-1:0] m_lat = '0;
    logic [N-1:0] hist[$];

    function automatic logic [N-1:0] m_port();
        return (hist.size() == 2) ? hist[0] : '0;
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_dir = '1;
            m_lat = '0;
            hist.delete();
        end else begin
            hist.push_back(pad_in);
            if (hist.size() > 2) void'(hist.pop_front());
            if (bus_wr) begin
                if (bus_addr == 2'd0) m_dir = bus_wdata;
                else if (bus_addr == 2'd1 || bus_addr == 2'd2) m_lat = bus_wdata;
            end
        end
    end

    task automatic check(string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        logic [N-1:0] e_rd, e_out, e_oe;
        if (rst_n) begin
            case (bus_addr)
                2'd0: e_rd = m_dir;
                2'd1: e_rd = m_port();
                2'd2: e_rd = m_lat;
                default: e_rd = '0;
            endcase
        end else begin
            case (bus_addr)
                2'd0: e_rd = '1;
                2'd2: e_rd = '0;
                default: e_rd = '0;
            endcase
        end
        e_out = (periph_en & periph_out) | (~periph_en & (rst_n ? m_lat : '0));
        e_oe  = (periph_en & periph_oe)  | (~periph_en & ~(rst_n ? m_dir : '1));
        check(cur_req, "rdata", bus_rdata, e_rd);
        check(cur_req, "pad_out", pad_out, e_out);
        check(cur_req, "pad_oe", pad_oe, e_oe);
    end

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic bus_write(logic [1:0] a, logic [N-1:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    // explicit checks, sampled at the falling edge
    task automatic expect_read(string req, logic [1:0] a, logic [N-1:0] exp);
        bus_addr = a;
        @(negedge clk);
        check(req, "read", bus_rdata, exp);
        #2;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        bus_addr = 2'd0;
        repeat (3) step();
        check("R1", "reset oe", pad_oe, '0);
        check("R1", "reset out", pad_out, '0);
        check("R1", "reset dir", bus_rdata, '1);
        rst_n = 1'b1;
        step();

        // R2: direction write and readback
        cur_req = "R2";
        bus_write(2'd0, 16'h00F0);
        expect_read("R2", 2'd0, 16'h00F0);

        // R3: port write lands in latch, direction untouched
        cur_req = "R3";
        bus_write(2'd1, 16'hA5A5);
        expect_read("R3", 2'd2, 16'hA5A5);
        expect_read("R3", 2'd0, 16'h00F0);

        // R7: driven pins follow latch, inputs disabled
        cur_req = "R7";
        @(negedge clk);
        check("R7", "pad_out", pad_out, 16'hA5A5);
        check("R7", "pad_oe", pad_oe, 16'hFF0F);
        #2;

        // R4: latch write
        cur_req = "R4";
        bus_write(2'd2, 16'h1234);
        expect_read("R4", 2'd2, 16'h1234);

        // R5: port read lags pad_in by two edges
        cur_req = "R5";
        bus_addr = 2'd1;
        pad_in = 16'hC3C3;
        step();
        pad_in = 16'h0F0F;
        step();
        check("R5", "port lag", bus_rdata, 16'hC3C3);
        step();
        check("R5", "port lag2", bus_rdata, 16'h0F0F);
        for (int i = 0; i < 8; i++) begin
            pad_in = N'(16'h1111 * i) ^ 16'h8001;
            step();
        end

        // R6: latch read ignores pad levels
        cur_req = "R6";
        pad_in = 16'hFFFF;
        repeat (3) step();
        expect_read("R6", 2'd2, 16'h1234);
        pad_in = 16'h0000;
        repeat (3) step();
        expect_read("R6", 2'd2, 16'h1234);

        // R8: peripheral takeover overrides direction and latch
        cur_req = "R8";
        bus_write(2'd0, 16'h0000);
        periph_en = 16'h0FF0; periph_out = 16'h0550; periph_oe = 16'h00F0;
        @(negedge clk);
        check("R8", "pad_out", pad_out, 16'h1554);
        check("R8", "pad_oe", pad_oe, 16'hF0FF);
        #2;
        periph_en = 16'hFFFF; periph_out = 16'h5A5A; periph_oe = 16'h0000;
        step();
        periph_en = '0;
        step();

        // R9: unused address reads zero, writes ignored
        cur_req = "R9";
        bus_write(2'd3, 16'hBEEF);
        expect_read("R9", 2'd3, 16'h0000);
        expect_read("R9", 2'd0, 16'h0000);
        expect_read("R9", 2'd2, 16'h1234);

        // R10: no strobe, no change
        cur_req = "R10";
        for (int i = 0; i < 6; i++) begin
            bus_addr = 2'(i); bus_wdata = 16'hDEAD + N'(i);
            step();
        end
        expect_read("R10", 2'd0, 16'h0000);
        expect_read("R10", 2'd2, 16'h1234);

        // mixed traffic
        cur_req = "R2";
        for (int i = 0; i < 20; i++) begin
            bus_write(2'(i % 3), N'(16'h9E37 * (i + 1)));
            pad_in = N'(16'h3C1D * i);
            step();
        end

        repeat (2) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // watchdog
    initial begin
        wait (cycles > 20000);
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule